// File: doc/BRIEF.md
# SPI Slave Memory Bridge

This block is an SPI mode 0 slave. It lets an external master read and write a set of on-chip synchronous memories, called banks. Every chip-select window carries one transaction. The master first sends a start address as two bytes, low byte first. It then sends a command byte. Bit 0 of the command byte sets the direction, and the bits above it pick the bank. After the command byte the master streams data bytes. Each byte goes to the next address, or comes from it, until chip select is released.

The SPI pins are sampled into the system clock domain through a short synchronizer. A shift stage finds the SCK edges and assembles bytes from them. A control stage decodes the header. It issues one write pulse per received data byte. For reads, it prefetches the next byte so that the byte is ready before the falling SCK edge that must present its MSB. Each bank gets its own memory port: address, write data, write enable and read data. The memory is assumed to return read data one clock after it sees an address.

Top module: `spi_bridge_top`

## Requirements
- R1: In SPI mode 0 (SCK idles low), MOSI is sampled on rising SCK edges. MISO changes only after falling SCK edges, so it holds steady for the whole time SCK is high.
- R2: Byte 1 of a transaction is address bits [7:0] and byte 2 is address bits [15:8]. Together they form the 16-bit start address.
- R3: Byte 3 is the command. Command bit 0 = 0 selects a write burst and bit 0 = 1 selects a read burst.
- R4: Command bits [7:1] are the bank index. If the index is NUM_BANKS or greater, write bytes raise no write enable and read bytes return 8'h00.
- R5: The address advances by one after each data byte of a burst. It wraps from 16'hFFFF to 16'h0000.
- R6: A write byte is committed only after all eight of its bits have arrived. The commit is a single-cycle pulse on mem_we of the selected bank only, with that bank's mem_addr and mem_wdata valid in the same cycle.
- R7: Releasing cs_n at any point ends the transaction. A partly received byte is discarded, and the next transaction starts again with the low address byte.
- R8: In a read burst, MISO carries the byte at the start address MSB-first, beginning with the first data byte (byte 4). Each later byte comes from the following address.
- R9: MISO is 0 while cs_n is high and during all three header bytes.
- R10: After reset, MISO is 0 and no mem_we bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-assert reset |
| sck | input | 1 | SPI serial clock from the master |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| mem_addr | output | NUM_BANKS*16 | Per-bank memory address, bank b at bits [b*16 +: 16] |
| mem_wdata | output | NUM_BANKS*8 | Per-bank write data, bank b at bits [b*8 +: 8] |
| mem_we | output | NUM_BANKS | Per-bank write enable, one-cycle pulse |
| mem_rdata | input | NUM_BANKS*8 | Per-bank read data, valid one clock after the address |

## Verification
The bench builds the bridge with NUM_BANKS = 3 and SYNC_STAGES = 2, and runs SCK at eight system clocks per half period. Three banks put one bank behind bit 2 of the command byte. They also leave index 3 and index 5 unpopulated, so the paths that drop writes and return zeros for reads can be reached. The eight-clock half period leaves the read prefetch a realistic margin before the falling edge that presents the first data bit.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = BYTE_W - 1;

  typedef enum logic [2:0] {
    PH_ADDR_LO,
    PH_ADDR_HI,
    PH_CMD,
    PH_WRITE,
    PH_READ
  } phase_t;

  // next address of a burst, wrapping at the top of the space
  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic cmd_is_read(input logic [BYTE_W-1:0] c);
    return c[0];
  endfunction

  function automatic logic [SEL_W-1:0] cmd_bank(input logic [BYTE_W-1:0] c);
    return c[BYTE_W-1:1];
  endfunction

endpackage

// File: rtl/spi_bridge_sync.sv
module spi_bridge_sync #(
  parameter int               WIDTH     = 3,
  parameter int               STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RESET_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_bridge_shifter.sv
module spi_bridge_shifter
  import spi_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] tx_next,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done,
  output logic              tx_bit
);

  localparam int CNT_W = $clog2(BYTE_W);

  logic              sck_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] rx_sh;
  logic [BYTE_W-1:0] tx_reg;
  logic              sck_rise;
  logic              sck_fall;
  logic              last_bit;

  assign sck_rise = sck_s & ~sck_d & ~cs_n_s;
  assign sck_fall = ~sck_s & sck_d & ~cs_n_s;
  assign last_bit = (bit_cnt == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d     <= 1'b0;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
      tx_reg    <= '0;
    end else begin
      sck_d     <= sck_s;
      byte_done <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
        tx_reg  <= '0;
      end else begin
        if (sck_rise) begin
          rx_sh   <= {rx_sh[BYTE_W-3:0], mosi_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (last_bit) begin
            rx_byte   <= {rx_sh, mosi_s};
            byte_done <= 1'b1;
          end
        end
        // byte boundary: present the next byte's MSB; otherwise advance
        if (sck_fall) tx_reg <= (bit_cnt == '0) ? tx_next : {tx_reg[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign tx_bit = tx_reg[BYTE_W-1];

  assert_byte_after_eight_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> ($past(sck_rise) && $past(bit_cnt) == CNT_W'(BYTE_W - 1)));

  assert_tx_still_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_s && sck_d && !cs_n_s) |=> $stable(tx_reg) || $past(cs_n_s));

endmodule

// File: rtl/spi_bridge_ctrl.sv
module spi_bridge_ctrl
  import spi_bridge_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cs_n_s,
  input  logic                        byte_done,
  input  logic [BYTE_W-1:0]           rx_byte,
  input  logic [NUM_BANKS*BYTE_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0]           ptr,
  output logic [BYTE_W-1:0]           wdata,
  output logic [NUM_BANKS-1:0]        we,
  output logic [BYTE_W-1:0]           tx_next,
  output phase_t                      phase
);

  logic [BYTE_W-1:0] cmd_q;
  logic [SEL_W-1:0]  bank_sel;
  logic              bank_ok;
  logic              wr_step;
  logic              rd_pend;
  logic              rd_cap;
  logic [BYTE_W-1:0] nxt_byte;
  logic [BYTE_W-1:0] sel_rdata;

  assign bank_sel = cmd_bank(cmd_q);
  assign bank_ok  = (bank_sel < SEL_W'(NUM_BANKS));

  always_comb begin
    sel_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_sel == SEL_W'(b)) sel_rdata = mem_rdata[b*BYTE_W +: BYTE_W];
  end

  assign tx_next = (phase == PH_READ) ? nxt_byte : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_ADDR_LO;
      ptr      <= '0;
      cmd_q    <= '0;
      wdata    <= '0;
      we       <= '0;
      wr_step  <= 1'b0;
      rd_pend  <= 1'b0;
      rd_cap   <= 1'b0;
      nxt_byte <= '0;
    end else begin
      we      <= '0;
      wr_step <= 1'b0;
      rd_pend <= 1'b0;
      rd_cap  <= rd_pend;
      if (rd_cap) nxt_byte <= bank_ok ? sel_rdata : '0;
      if (wr_step) ptr <= addr_step(ptr);
      if (cs_n_s) begin
        phase  <= PH_ADDR_LO;
        rd_cap <= 1'b0;
      end else if (byte_done) begin
        unique case (phase)
          PH_ADDR_LO: begin
            ptr[BYTE_W-1:0] <= rx_byte;
            phase <= PH_ADDR_HI;
          end
          PH_ADDR_HI: begin
            ptr[ADDR_W-1:BYTE_W] <= rx_byte;
            phase <= PH_CMD;
          end
          PH_CMD: begin
            cmd_q   <= rx_byte;
            rd_pend <= cmd_is_read(rx_byte);
            phase   <= cmd_is_read(rx_byte) ? PH_READ : PH_WRITE;
          end
          PH_WRITE: begin
            wdata   <= rx_byte;
            wr_step <= 1'b1;
            for (int b = 0; b < NUM_BANKS; b++)
              we[b] <= bank_ok && (bank_sel == SEL_W'(b));
          end
          PH_READ: begin
            ptr     <= addr_step(ptr);
            rd_pend <= 1'b1;
          end
          default: phase <= PH_ADDR_LO;
        endcase
      end
    end
  end

  assert_single_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));

  assert_we_from_write_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|we) |-> ($past(byte_done) && $past(phase) == PH_WRITE));

  assert_ptr_advances_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|we) |=> ptr == addr_step($past(ptr)));

  assert_abort_to_header_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> phase == PH_ADDR_LO);

  assert_prefetch_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap |-> $past(rd_pend));

endmodule

// File: rtl/spi_bridge_top.sv
module spi_bridge_top
  import spi_bridge_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sck,
  input  logic                        cs_n,
  input  logic                        mosi,
  output logic                        miso,
  output logic [NUM_BANKS*ADDR_W-1:0] mem_addr,
  output logic [NUM_BANKS*BYTE_W-1:0] mem_wdata,
  output logic [NUM_BANKS-1:0]        mem_we,
  input  logic [NUM_BANKS*BYTE_W-1:0] mem_rdata
);

  logic              sck_s, cs_n_s, mosi_s;
  logic [BYTE_W-1:0] rx_byte, tx_next, wdata;
  logic              byte_done, tx_bit;
  logic [ADDR_W-1:0] ptr;
  phase_t            phase;

  spi_bridge_sync #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b010)
  ) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck, cs_n, mosi}),
    .q({sck_s, cs_n_s, mosi_s})
  );

  spi_bridge_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .sck_s(sck_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .tx_next(tx_next), .rx_byte(rx_byte),
    .byte_done(byte_done), .tx_bit(tx_bit)
  );

  spi_bridge_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(cs_n_s), .byte_done(byte_done), .rx_byte(rx_byte),
    .mem_rdata(mem_rdata),
    .ptr(ptr), .wdata(wdata), .we(mem_we),
    .tx_next(tx_next), .phase(phase)
  );

  assign mem_addr  = {NUM_BANKS{ptr}};
  assign mem_wdata = {NUM_BANKS{wdata}};
  assign miso      = cs_n ? 1'b0 : tx_bit;

  assert_header_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ADDR_LO || phase == PH_ADDR_HI || phase == PH_CMD) |-> miso == 1'b0);

endmodule

// File: tb/spi_bridge_top_test.sv
`timescale 1ns/1ps
module spi_bridge_top_test;

  localparam int NB   = 3;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [NB*16-1:0] mem_addr;
  logic [NB*8-1:0]  mem_wdata;
  logic [NB-1:0]    mem_we;
  logic [NB*8-1:0]  mem_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_bridge_top #(.NUM_BANKS(NB), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] seed_val(int b, int i);
    return 8'(b * 61 + i * 7 + 5);
  endfunction

  // memory model, one synchronous port per bank
  logic [7:0] ram [NB][256];
  logic [7:0] exp_mem [NB][256];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++)
        for (int i = 0; i < 256; i++) ram[b][i] <= seed_val(b, i);
      mem_rdata <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (mem_we[b]) ram[b][mem_addr[b*16 +: 8]] <= mem_wdata[b*8 +: 8];
        mem_rdata[b*8 +: 8] <= ram[b][mem_addr[b*16 +: 8]];
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard of expected commits
  typedef struct packed {
    logic [7:0]  bank;
    logic [15:0] addr;
    logic [7:0]  data;
  } wr_t;
  wr_t exp_q[$];

  always @(negedge clk) begin
    if (rst_n) begin
      for (int b = 0; b < NB; b++) begin
        if (mem_we[b]) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R4/R6 unexpected write", {8'(b), mem_addr[b*16 +: 16], mem_wdata[b*8 +: 8]}, 32'h0);
          end else begin
            wr_t e;
            e = exp_q.pop_front();
            check(e.bank == 8'(b) && e.addr == mem_addr[b*16 +: 16] && e.data == mem_wdata[b*8 +: 8],
                  "R2/R5/R6 write commit",
                  {8'(b), mem_addr[b*16 +: 16], mem_wdata[b*8 +: 8]}, {e.bank, e.addr, e.data});
          end
          check($countones(mem_we) == 1, "R6 single bank", 32'(mem_we), 32'(1 << b));
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      logic m0;
      mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      m0 = miso;
      sck = 1'b1;
      wait_clk(HALF);
      check(miso == m0, "R1 miso steady while sck high", 32'(miso), 32'(m0));
      sck = 1'b0;
    end
  endtask

  task automatic spi_xfer(input logic [7:0] tx, output logic [7:0] rx);
    spi_bits(tx, 8, rx);
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_end();
    wait_clk(HALF);
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_clk(4 * HALF);
    check(miso == 1'b0, "R9 miso idle", 32'(miso), 32'h0);
    check(exp_q.size() == 0, "R6 all commits seen", 32'(exp_q.size()), 32'h0);
  endtask

  task automatic send_header(input logic [15:0] addr, input logic [7:0] cmd);
    logic [7:0] rx;
    spi_xfer(addr[7:0], rx);
    check(rx == 8'h00, "R9 header byte 1 quiet", 32'(rx), 32'h0);
    spi_xfer(addr[15:8], rx);
    check(rx == 8'h00, "R9 header byte 2 quiet", 32'(rx), 32'h0);
    spi_xfer(cmd, rx);
    check(rx == 8'h00, "R9 header byte 3 quiet", 32'(rx), 32'h0);
  endtask

  task automatic do_write(input int bank, input logic [15:0] addr, input int n, input logic [7:0] seed);
    logic [7:0] rx;
    cs_begin();
    send_header(addr, 8'(bank << 1));
    for (int k = 0; k < n; k++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = addr + 16'(k);
      d = seed + 8'(k * 13);
      if (bank < NB) begin
        exp_q.push_back({8'(bank), a, d});
        exp_mem[bank][a[7:0]] = d;
      end
      spi_xfer(d, rx);
    end
    cs_end();
  endtask

  task automatic do_read(input int bank, input logic [15:0] addr, input int n, input string req);
    logic [7:0] rx;
    cs_begin();
    send_header(addr, 8'((bank << 1) | 1));
    for (int k = 0; k < n; k++) begin
      logic [15:0] a;
      logic [7:0]  e;
      a = addr + 16'(k);
      e = (bank < NB) ? exp_mem[bank][a[7:0]] : 8'h00;
      spi_xfer(8'hA5, rx);
      check(rx == e, req, {8'(bank), a, rx}, {8'(bank), a, e});
    end
    cs_end();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rx;
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < 256; i++) exp_mem[b][i] = seed_val(b, i);
    wait_clk(6);
    check(miso == 1'b0, "R10 reset miso", 32'(miso), 32'h0);
    check(mem_we == '0, "R10 reset we", 32'(mem_we), 32'h0);
    rst_n = 1'b1;
    wait_clk(6);
    check(miso == 1'b0, "R10 post-reset miso", 32'(miso), 32'h0);

    // R2 R3 R6: write bursts to two banks
    do_write(0, 16'h1234, 4, 8'h3C);
    do_write(2, 16'h00FE, 3, 8'hC1);
    // R8 R3: read them back, plus untouched preload in bank 1
    do_read(0, 16'h1234, 4, "R8 read bank0");
    do_read(2, 16'h00FE, 3, "R8 read bank2");
    do_read(1, 16'h0740, 5, "R8 read bank1 preload");
    // R5: wrap at the top of the address space
    do_write(1, 16'hFFFF, 2, 8'h77);
    do_read(1, 16'hFFFE, 4, "R5 read across wrap");
    // R4: unpopulated banks drop writes and read zero
    do_write(3, 16'h0010, 2, 8'h99);
    do_write(5, 16'h0011, 2, 8'h55);
    do_read(3, 16'h0010, 3, "R4 read missing bank");
    do_read(0, 16'h0010, 2, "R4 bank0 untouched");

    // R7 R6: abort mid data byte, partial byte not committed
    cs_begin();
    send_header(16'h0300, 8'h00);
    exp_q.push_back({8'd0, 16'h0300, 8'hE7});
    exp_mem[0][8'h00] = 8'hE7;
    spi_xfer(8'hE7, rx);
    spi_bits(8'h18, 4, rx);
    cs_end();
    // R7: abort inside the header, then a fresh transaction decodes from byte 1
    cs_begin();
    spi_xfer(8'h44, rx);
    spi_bits(8'h01, 5, rx);
    cs_end();
    do_write(0, 16'h0205, 1, 8'h6D);
    do_read(0, 16'h02FF, 3, "R7 read after aborts");

    wait_clk(20);
    finish_run();
  end

endmodule